// File: doc/BRIEF.md
# Native Display Mode Selector

This block watches a stream of already-decoded display timing descriptors and picks the native mode of the attached screen. A list of descriptors opens with a start marker and closes with an end marker. Inside the list, every descriptor that is a real timing entry with a running pixel clock competes on one measure: horizontal active width. The widest one wins. A later entry with the same width does not displace the earlier one, and vertical size plays no part in the choice.

As each descriptor arrives, the block turns its relative blanking fields into absolute line and frame positions, sync start, sync end and total, on both axes. It also scales the pixel clock into output units and works out the sync polarity and interlace flags. The winner is kept in a best-so-far register set. One cycle after the end marker, the block copies the winner to the registered result outputs, together with a validity flag and the screen's digital-input flag. The results then hold until the next list begins.

Top module: `dtd_native_sel`

## Requirements
- R1: A descriptor is a candidate only when `desc_valid` is high, `desc_is_timing` is high and `desc_pclk` is nonzero. Any other descriptor leaves the selection unchanged.
- R2: A candidate replaces the best-so-far entry only when its horizontal active width is strictly greater. With equal widths the earlier entry stays, and the vertical fields are never compared.
- R3: For each axis, sync start is active plus sync offset, sync end is sync start plus sync width, and total is active plus blanking. Each sum is formed at DIM_W+2 bits, so it is never truncated.
- R4: `res_pclk` is ten times the winning descriptor's `desc_pclk`, at CLK_W+4 bits.
- R5: The sync type field value 2'b11 selects separate syncs. With that value, `res_hsync_pos` is `desc_misc[0]` and `res_vsync_pos` is `desc_misc[1]`. With any other sync type, both flags are 0.
- R6: `res_interlace` is the winning descriptor's `desc_interlace` bit.
- R7: At the end marker, `res_valid` becomes 1 only if both the horizontal and the vertical display sizes of the winner are nonzero. A list with no candidate gives 0 on every result.
- R8: `res_digital` is the value on `disp_digital` in the end-marker cycle.
- R9: `list_start` empties the best-so-far set. A descriptor in the same cycle as `list_start` is judged against the empty set. `res_valid` is 0 in the cycle after `list_start`.
- R10: The results change exactly one cycle after `list_end`, and a descriptor in the end-marker cycle takes part in the selection. Without a marker, the results hold whatever descriptors arrive.
- R11: During and right after reset, every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_start | input | 1 | Opens a new descriptor list |
| list_end | input | 1 | Closes the list; results follow one cycle later |
| desc_valid | input | 1 | Descriptor fields are present this cycle |
| desc_is_timing | input | 1 | Descriptor is a detailed timing entry |
| desc_pclk | input | CLK_W | Pixel clock in descriptor units |
| desc_h_active | input | DIM_W | Horizontal active pixels |
| desc_h_sync_ofs | input | DIM_W | Horizontal sync offset from end of active |
| desc_h_sync_wid | input | DIM_W | Horizontal sync pulse width |
| desc_h_blank | input | DIM_W | Horizontal blanking |
| desc_v_active | input | DIM_W | Vertical active lines |
| desc_v_sync_ofs | input | DIM_W | Vertical sync offset from end of active |
| desc_v_sync_wid | input | DIM_W | Vertical sync pulse width |
| desc_v_blank | input | DIM_W | Vertical blanking |
| desc_sync_type | input | 2 | Sync type code (2'b11 = separate syncs) |
| desc_misc | input | 2 | Polarity bits: [0] horizontal, [1] vertical |
| desc_interlace | input | 1 | Interlaced timing |
| disp_digital | input | 1 | Screen input type is digital (sampled at end marker) |
| res_valid | output | 1 | Native mode found with nonzero dimensions |
| res_pclk | output | CLK_W+4 | Pixel clock times ten |
| res_h_disp | output | DIM_W+2 | Horizontal display width |
| res_h_sync_start | output | DIM_W+2 | Horizontal sync start |
| res_h_sync_end | output | DIM_W+2 | Horizontal sync end |
| res_h_total | output | DIM_W+2 | Horizontal total |
| res_v_disp | output | DIM_W+2 | Vertical display height |
| res_v_sync_start | output | DIM_W+2 | Vertical sync start |
| res_v_sync_end | output | DIM_W+2 | Vertical sync end |
| res_v_total | output | DIM_W+2 | Vertical total |
| res_hsync_pos | output | 1 | Positive horizontal sync |
| res_vsync_pos | output | 1 | Positive vertical sync |
| res_interlace | output | 1 | Interlaced mode |
| res_digital | output | 1 | Digital input screen |

## Verification
The best-so-far set is loaded on the same edge that samples a descriptor. The result registers load on the edge that samples `list_end`. So every result is due exactly one cycle after the end-marker cycle, and the cleared `res_valid` is due one cycle after the start-marker cycle. The driver pushes its expected result when it raises `list_end`. The monitor waits for the clock edge that samples that marker and compares at the following falling edge, so each check sits in the single cycle where the value must first appear. The hold checks and the cleared-valid checks are taken at falling edges after later stimulus, which shows that nothing moved earlier or later than due.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int unsigned DEF_CLK_W = 16;
  localparam int unsigned DEF_DIM_W = 12;
  localparam logic [1:0]  SYNC_SEPARATE = 2'b11;

  typedef struct packed {
    logic hpos;
    logic vpos;
    logic ilace;
  } dtd_flags_t;
endpackage

// File: rtl/dtd_axis.sv
module dtd_axis #(
  parameter int unsigned DIM_W = 12,
  localparam int unsigned RES_W = DIM_W + 2
) (
  input  logic [DIM_W-1:0]      active,
  input  logic [DIM_W-1:0]      sync_ofs,
  input  logic [DIM_W-1:0]      sync_wid,
  input  logic [DIM_W-1:0]      blank,
  output logic [3:0][RES_W-1:0] vals   // 0 disp, 1 sync start, 2 sync end, 3 total
);
  logic [RES_W-1:0] act_x, ss_x;

  always_comb begin
    act_x   = RES_W'(active);
    ss_x    = act_x + RES_W'(sync_ofs);
    vals[0] = act_x;
    vals[1] = ss_x;
    vals[2] = ss_x + RES_W'(sync_wid);
    vals[3] = act_x + RES_W'(blank);
  end
endmodule

// File: rtl/dtd_best.sv
module dtd_best
  import dtd_pkg::*;
#(
  parameter int unsigned CLK_W = 16,
  parameter int unsigned DIM_W = 12,
  localparam int unsigned RES_W  = DIM_W + 2,
  localparam int unsigned PCLK_W = CLK_W + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  list_start,
  input  logic                  desc_valid,
  input  logic                  desc_is_timing,
  input  logic [CLK_W-1:0]      desc_pclk,
  input  logic [PCLK_W-1:0]     cand_pclk,
  input  logic [3:0][RES_W-1:0] cand_h,
  input  logic [3:0][RES_W-1:0] cand_v,
  input  dtd_flags_t            cand_flags,
  output logic [PCLK_W-1:0]     nxt_pclk,
  output logic [3:0][RES_W-1:0] nxt_h,
  output logic [3:0][RES_W-1:0] nxt_v,
  output dtd_flags_t            nxt_flags
);
  logic [PCLK_W-1:0]     best_pclk;
  logic [3:0][RES_W-1:0] best_h;
  logic [3:0][RES_W-1:0] best_v;
  dtd_flags_t            best_flags;

  logic [RES_W-1:0] base_width;
  logic             qualified;
  logic             take;
  logic             load_en;

  always_comb begin
    base_width = list_start ? '0 : best_h[0];
    qualified  = desc_valid && desc_is_timing && (desc_pclk != '0);
    take       = qualified && (cand_h[0] > base_width);
    load_en    = list_start || take;
    if (take) begin
      nxt_pclk  = cand_pclk;
      nxt_h     = cand_h;
      nxt_v     = cand_v;
      nxt_flags = cand_flags;
    end else if (list_start) begin
      nxt_pclk  = '0;
      nxt_h     = '0;
      nxt_v     = '0;
      nxt_flags = '0;
    end else begin
      nxt_pclk  = best_pclk;
      nxt_h     = best_h;
      nxt_v     = best_v;
      nxt_flags = best_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_pclk  <= '0;
      best_h     <= '0;
      best_v     <= '0;
      best_flags <= '0;
    end else if (load_en) begin
      best_pclk  <= nxt_pclk;
      best_h     <= nxt_h;
      best_v     <= nxt_v;
      best_flags <= nxt_flags;
    end
  end

  // R2
  best_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !list_start |=> best_h[0] >= $past(best_h[0]));

  // R1
  zero_clk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_pclk == '0 && !list_start) |=> $stable(best_h) && $stable(best_pclk));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_start && !desc_valid) |=> (best_h[0] == '0) && (best_pclk == '0));
endmodule

// File: rtl/dtd_result.sv
module dtd_result
  import dtd_pkg::*;
#(
  parameter int unsigned CLK_W = 16,
  parameter int unsigned DIM_W = 12,
  localparam int unsigned RES_W  = DIM_W + 2,
  localparam int unsigned PCLK_W = CLK_W + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  list_start,
  input  logic                  list_end,
  input  logic                  disp_digital,
  input  logic [PCLK_W-1:0]     nxt_pclk,
  input  logic [3:0][RES_W-1:0] nxt_h,
  input  logic [3:0][RES_W-1:0] nxt_v,
  input  dtd_flags_t            nxt_flags,
  output logic                  res_valid,
  output logic [PCLK_W-1:0]     res_pclk,
  output logic [3:0][RES_W-1:0] res_h,
  output logic [3:0][RES_W-1:0] res_v,
  output dtd_flags_t            res_flags,
  output logic                  res_digital
);
  logic valid_nxt;
  logic valid_en;

  always_comb begin
    valid_en  = list_end || list_start;
    valid_nxt = list_end ? ((nxt_h[0] != '0) && (nxt_v[0] != '0)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else if (valid_en) begin
      res_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pclk    <= '0;
      res_h       <= '0;
      res_v       <= '0;
      res_flags   <= '0;
      res_digital <= 1'b0;
    end else if (list_end) begin
      res_pclk    <= nxt_pclk;
      res_h       <= nxt_h;
      res_v       <= nxt_v;
      res_flags   <= nxt_flags;
      res_digital <= disp_digital;
    end
  end

  // R7
  valid_needs_dims_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_h[0] != '0) && (res_v[0] != '0));

  // R10
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!list_start && !list_end) |=> $stable(res_valid) && $stable(res_pclk) && $stable(res_h) && $stable(res_v));

  // R10
  valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(list_end));
endmodule

// File: rtl/dtd_native_sel.sv
module dtd_native_sel
  import dtd_pkg::*;
#(
  parameter int unsigned CLK_W = DEF_CLK_W,
  parameter int unsigned DIM_W = DEF_DIM_W,
  localparam int unsigned RES_W  = DIM_W + 2,
  localparam int unsigned PCLK_W = CLK_W + 4,
  localparam int unsigned N_AXES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              list_start,
  input  logic              list_end,
  input  logic              desc_valid,
  input  logic              desc_is_timing,
  input  logic [CLK_W-1:0]  desc_pclk,
  input  logic [DIM_W-1:0]  desc_h_active,
  input  logic [DIM_W-1:0]  desc_h_sync_ofs,
  input  logic [DIM_W-1:0]  desc_h_sync_wid,
  input  logic [DIM_W-1:0]  desc_h_blank,
  input  logic [DIM_W-1:0]  desc_v_active,
  input  logic [DIM_W-1:0]  desc_v_sync_ofs,
  input  logic [DIM_W-1:0]  desc_v_sync_wid,
  input  logic [DIM_W-1:0]  desc_v_blank,
  input  logic [1:0]        desc_sync_type,
  input  logic [1:0]        desc_misc,
  input  logic              desc_interlace,
  input  logic              disp_digital,
  output logic              res_valid,
  output logic [PCLK_W-1:0] res_pclk,
  output logic [RES_W-1:0]  res_h_disp,
  output logic [RES_W-1:0]  res_h_sync_start,
  output logic [RES_W-1:0]  res_h_sync_end,
  output logic [RES_W-1:0]  res_h_total,
  output logic [RES_W-1:0]  res_v_disp,
  output logic [RES_W-1:0]  res_v_sync_start,
  output logic [RES_W-1:0]  res_v_sync_end,
  output logic [RES_W-1:0]  res_v_total,
  output logic              res_hsync_pos,
  output logic              res_vsync_pos,
  output logic              res_interlace,
  output logic              res_digital
);
  logic [N_AXES-1:0][DIM_W-1:0] ax_act, ax_ofs, ax_wid, ax_blk;
  logic [N_AXES-1:0][3:0][RES_W-1:0] ax_vals;

  assign ax_act = {desc_v_active,   desc_h_active};
  assign ax_ofs = {desc_v_sync_ofs, desc_h_sync_ofs};
  assign ax_wid = {desc_v_sync_wid, desc_h_sync_wid};
  assign ax_blk = {desc_v_blank,    desc_h_blank};

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    dtd_axis #(.DIM_W(DIM_W)) u_axis (
      .active   (ax_act[a]),
      .sync_ofs (ax_ofs[a]),
      .sync_wid (ax_wid[a]),
      .blank    (ax_blk[a]),
      .vals     (ax_vals[a])
    );
  end

  logic [PCLK_W-1:0] pclk_ext;
  logic [PCLK_W-1:0] cand_pclk;
  dtd_flags_t        cand_flags;
  logic              sep_sync;

  always_comb begin
    pclk_ext         = PCLK_W'(desc_pclk);
    cand_pclk        = (pclk_ext << 3) + (pclk_ext << 1);
    sep_sync         = (desc_sync_type == SYNC_SEPARATE);
    cand_flags.hpos  = sep_sync & desc_misc[0];
    cand_flags.vpos  = sep_sync & desc_misc[1];
    cand_flags.ilace = desc_interlace;
  end

  logic [PCLK_W-1:0]     nxt_pclk;
  logic [3:0][RES_W-1:0] nxt_h, nxt_v;
  dtd_flags_t            nxt_flags;

  dtd_best #(.CLK_W(CLK_W), .DIM_W(DIM_W)) u_best (
    .clk            (clk),
    .rst_n          (rst_n),
    .list_start     (list_start),
    .desc_valid     (desc_valid),
    .desc_is_timing (desc_is_timing),
    .desc_pclk      (desc_pclk),
    .cand_pclk      (cand_pclk),
    .cand_h         (ax_vals[0]),
    .cand_v         (ax_vals[1]),
    .cand_flags     (cand_flags),
    .nxt_pclk       (nxt_pclk),
    .nxt_h          (nxt_h),
    .nxt_v          (nxt_v),
    .nxt_flags      (nxt_flags)
  );

  logic [3:0][RES_W-1:0] out_h, out_v;
  dtd_flags_t            out_flags;

  dtd_result #(.CLK_W(CLK_W), .DIM_W(DIM_W)) u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .list_start   (list_start),
    .list_end     (list_end),
    .disp_digital (disp_digital),
    .nxt_pclk     (nxt_pclk),
    .nxt_h        (nxt_h),
    .nxt_v        (nxt_v),
    .nxt_flags    (nxt_flags),
    .res_valid    (res_valid),
    .res_pclk     (res_pclk),
    .res_h        (out_h),
    .res_v        (out_v),
    .res_flags    (out_flags),
    .res_digital  (res_digital)
  );

  assign res_h_disp       = out_h[0];
  assign res_h_sync_start = out_h[1];
  assign res_h_sync_end   = out_h[2];
  assign res_h_total      = out_h[3];
  assign res_v_disp       = out_v[0];
  assign res_v_sync_start = out_v[1];
  assign res_v_sync_end   = out_v[2];
  assign res_v_total      = out_v[3];
  assign res_hsync_pos    = out_flags.hpos;
  assign res_vsync_pos    = out_flags.vpos;
  assign res_interlace    = out_flags.ilace;

  // R5
  sep_sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (list_end && desc_valid && desc_sync_type != SYNC_SEPARATE && nxt_h[0] == ax_vals[0][0] && nxt_pclk == cand_pclk && desc_pclk != '0 && desc_is_timing)
    |=> !res_hsync_pos && !res_vsync_pos);
endmodule

// File: tb/dtd_native_sel_test.sv
module dtd_native_sel_test;
  localparam int CLK_W = 16;
  localparam int DIM_W = 12;
  localparam int RES_W = DIM_W + 2;
  localparam int PCLK_W = CLK_W + 4;

  logic clk = 1'b0;
  logic rst_n;
  logic list_start, list_end, desc_valid, desc_is_timing;
  logic [CLK_W-1:0] desc_pclk;
  logic [DIM_W-1:0] h_a, h_o, h_w, h_b, v_a, v_o, v_w, v_b;
  logic [1:0] sync_type, misc;
  logic ilace, digital;
  logic res_valid;
  logic [PCLK_W-1:0] res_pclk;
  logic [RES_W-1:0] r_hd, r_hss, r_hse, r_ht, r_vd, r_vss, r_vse, r_vt;
  logic r_hp, r_vp, r_il, r_dg;

  always #2 clk = ~clk;

  dtd_native_sel #(.CLK_W(CLK_W), .DIM_W(DIM_W)) uut (
    .clk(clk), .rst_n(rst_n), .list_start(list_start), .list_end(list_end),
    .desc_valid(desc_valid), .desc_is_timing(desc_is_timing), .desc_pclk(desc_pclk),
    .desc_h_active(h_a), .desc_h_sync_ofs(h_o), .desc_h_sync_wid(h_w), .desc_h_blank(h_b),
    .desc_v_active(v_a), .desc_v_sync_ofs(v_o), .desc_v_sync_wid(v_w), .desc_v_blank(v_b),
    .desc_sync_type(sync_type), .desc_misc(misc), .desc_interlace(ilace),
    .disp_digital(digital),
    .res_valid(res_valid), .res_pclk(res_pclk),
    .res_h_disp(r_hd), .res_h_sync_start(r_hss), .res_h_sync_end(r_hse), .res_h_total(r_ht),
    .res_v_disp(r_vd), .res_v_sync_start(r_vss), .res_v_sync_end(r_vse), .res_v_total(r_vt),
    .res_hsync_pos(r_hp), .res_vsync_pos(r_vp), .res_interlace(r_il), .res_digital(r_dg)
  );

  typedef struct {
    bit vld;
    longint pclk;
    logic [4*RES_W-1:0] h;
    logic [4*RES_W-1:0] v;
    logic [3:0] flg;   // hpos, vpos, ilace, digital
    string tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t last_exp;
  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model of the selection
  longint m_pclk;
  int m_h[4], m_v[4];
  bit m_hp, m_vp, m_il;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [4*RES_W-1:0] pack4(input int a[4]);
    return {RES_W'(a[3]), RES_W'(a[2]), RES_W'(a[1]), RES_W'(a[0])};
  endfunction

  task automatic compare(input exp_t e);
    logic [4*RES_W-1:0] ah, av;
    ah = {r_ht, r_hse, r_hss, r_hd};
    av = {r_vt, r_vse, r_vss, r_vd};
    chk(res_valid == e.vld, {e.tag, " R7 valid"}, "", longint'(res_valid), longint'(e.vld));
    chk(longint'(res_pclk) == e.pclk, {e.tag, " R4 pclk"}, "", longint'(res_pclk), e.pclk);
    chk(ah == e.h, {e.tag, " R3 horiz"}, "", longint'(ah), longint'(e.h));
    chk(av == e.v, {e.tag, " R3 vert"}, "", longint'(av), longint'(e.v));
    chk({r_hp, r_vp, r_il, r_dg} == e.flg, {e.tag, " R5/R6/R8 flags"}, "",
        longint'({r_hp, r_vp, r_il, r_dg}), longint'(e.flg));
  endtask

  task automatic step(input bit s, input bit e, input bit dv, input bit tm,
                      input int pc, input int ha, input int ho, input int hw, input int hb,
                      input int va, input int vo, input int vw, input int vb,
                      input int st, input int ms, input bit il, input bit dg,
                      input string tag);
    exp_t x;
    @(negedge clk);
    list_start = s; list_end = e; desc_valid = dv; desc_is_timing = tm;
    desc_pclk = CLK_W'(pc);
    h_a = DIM_W'(ha); h_o = DIM_W'(ho); h_w = DIM_W'(hw); h_b = DIM_W'(hb);
    v_a = DIM_W'(va); v_o = DIM_W'(vo); v_w = DIM_W'(vw); v_b = DIM_W'(vb);
    sync_type = 2'(st); misc = 2'(ms); ilace = il; digital = dg;
    if (s) begin
      m_pclk = 0; m_h = '{0, 0, 0, 0}; m_v = '{0, 0, 0, 0};
      m_hp = 0; m_vp = 0; m_il = 0;
    end
    if (dv && tm && pc != 0 && ha > m_h[0]) begin
      m_pclk = longint'(pc) * 10;
      m_h = '{ha, ha + ho, ha + ho + hw, ha + hb};
      m_v = '{va, va + vo, va + vo + vw, va + vb};
      m_hp = (st == 3) && ms[0];
      m_vp = (st == 3) && ms[1];
      m_il = il;
    end
    if (e) begin
      x.vld = (m_h[0] != 0) && (m_v[0] != 0);
      x.pclk = m_pclk;
      x.h = pack4(m_h);
      x.v = pack4(m_v);
      x.flg = {m_hp, m_vp, m_il, dg};
      x.tag = tag;
      sb_q.push_back(x);
      last_exp = x;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor: result due one cycle after the end marker is sampled
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && list_end) begin
        @(negedge clk);
        if (sb_q.size() == 0) chk(0, "R10", "unexpected result", 1, 0);
        else compare(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      chk(0, "watchdog", "timeout", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    list_start = 0; list_end = 0; desc_valid = 0; desc_is_timing = 0; desc_pclk = '0;
    h_a = '0; h_o = '0; h_w = '0; h_b = '0; v_a = '0; v_o = '0; v_w = '0; v_b = '0;
    sync_type = '0; misc = '0; ilace = 0; digital = 0;
    m_pclk = 0; m_h = '{0, 0, 0, 0}; m_v = '{0, 0, 0, 0}; m_hp = 0; m_vp = 0; m_il = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({res_valid, res_pclk, r_hd, r_ht, r_vd, r_vt, r_hp, r_vp, r_il, r_dg} == '0,
        "R11 reset", "outputs", longint'(res_pclk), 0);
    rst_n = 1'b1;
    idle();
    chk(res_valid == 0 && r_hd == 0, "R11 after release", "outputs", longint'(r_hd), 0);

    // widest wins, polarity from misc with separate syncs (R2 R3 R4 R5)
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 1, 1, 2517, 640, 16, 96, 160, 480, 10, 2, 45, 3, 1, 0, 0, "");
    step(0, 0, 1, 1, 10800, 1280, 48, 112, 408, 1024, 1, 3, 42, 3, 2, 0, 0, "");
    step(0, 0, 1, 1, 6500, 1024, 24, 136, 320, 768, 3, 6, 38, 3, 3, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 widest");
    idle();

    // R9: start clears valid one cycle later
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    idle();
    chk(res_valid == 0, "R9 start clears valid", "res_valid", longint'(res_valid), 0);

    // R1: non-timing, zero clock and unstrobed fields ignored; R5 non-separate sync
    step(0, 0, 1, 0, 14850, 1920, 88, 44, 280, 1080, 4, 5, 45, 3, 3, 0, 0, "");
    step(0, 0, 1, 1, 0, 1600, 64, 192, 560, 1200, 1, 3, 50, 3, 3, 0, 0, "");
    step(0, 0, 1, 1, 4000, 800, 40, 128, 256, 600, 1, 4, 28, 2, 3, 0, 0, "");
    step(0, 0, 0, 1, 9000, 2000, 1, 1, 1, 900, 1, 1, 1, 3, 3, 1, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 ignored");
    idle();

    // R2: equal width keeps the first; vertical not compared; R6 interlace
    step(1, 0, 1, 1, 6500, 1024, 24, 136, 320, 768, 3, 6, 38, 1, 0, 0, 0, "");
    step(0, 0, 1, 1, 7000, 1024, 8, 8, 100, 900, 1, 1, 10, 3, 3, 1, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 equal width");
    idle();

    // R6: interlaced winner
    step(1, 0, 1, 1, 7425, 1920, 88, 44, 280, 540, 2, 5, 22, 3, 1, 1, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 interlace");
    idle();

    // R7: zero vertical size gives invalid
    step(1, 0, 1, 1, 8550, 1366, 70, 143, 426, 0, 3, 3, 30, 3, 0, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 zero vert");
    idle();

    // R7: empty list
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 empty");
    idle();

    // R9: a second start discards the earlier best
    step(1, 0, 1, 1, 14850, 1920, 88, 44, 280, 1080, 4, 5, 45, 3, 3, 0, 0, "");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 1, 1, 4000, 800, 40, 128, 256, 600, 1, 4, 28, 3, 1, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 restart");
    idle();

    // R10: descriptors on the marker cycles themselves (R9 same-cycle start)
    step(1, 0, 1, 1, 2700, 720, 16, 62, 138, 480, 9, 6, 45, 3, 0, 0, 0, "");
    step(0, 1, 1, 1, 5400, 1440, 32, 124, 276, 480, 9, 6, 45, 3, 2, 1, 1, "R10 marker cycles");
    idle();

    // R10: results hold without markers
    step(0, 0, 1, 1, 14850, 1920, 88, 44, 280, 1080, 4, 5, 45, 3, 3, 0, 0, "");
    step(0, 0, 1, 1, 20000, 2560, 48, 32, 160, 1440, 3, 5, 41, 3, 3, 1, 0, "");
    idle();
    idle();
    compare('{vld: last_exp.vld, pclk: last_exp.pclk, h: last_exp.h, v: last_exp.v,
              flg: last_exp.flg, tag: "R10 hold"});

    repeat (3) idle();
    chk(sb_q.size() == 0, "R10 scoreboard drained", "queue", sb_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule